// File: doc/BRIEF.md
# GPIO interrupt event controller

This block watches 32 general-purpose input pins and turns selected input activity into a single interrupt line. Each pin has a 2-bit event type. The type chooses rising edges, falling edges, both edges, or a low level. A detected event sets a sticky status bit for that pin. Software clears the bit by writing a 1 to it. A per-pin enable mask decides which status bits can drive the interrupt output.

The pins may change at any time relative to the clock, so each one passes through a two-flop synchronizer before detection. Software reaches the block through a flat 32-bit register port. Writes take effect on the clock edge, and reads return data combinationally from the byte address. Two type registers hold the event types, 16 pins in each. The pin with the lowest number in each group sits in the top two bits of its register.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After reset the status, mask and both type registers read zero, and `irq_out` is low.
- R2: The registers sit at these byte offsets: status 0x0C, mask 0x10, low-group type 0x14, high-group type 0x18. The mask and both type registers read back the last value written to them.
- R3: Pin p (0..15) takes its type from register 0x14 and pin p (16..31) from register 0x18. In either case the field occupies bits [2k+1:2k] with k = 15 − (p mod 16), so pin 0 uses bits 31:30 of 0x14 and pin 31 uses bits 1:0 of 0x18.
- R4: Type 2'b01 sets the pin's status bit on a 0→1 input transition. Type 2'b10 sets it on a 1→0 transition. Type 2'b00 sets it on either transition.
- R5: Type 2'b11 sets the pin's status bit whenever the synchronized input is low. The bit therefore sets again after a clear for as long as the pin stays low.
- R6: A pin change driven before clock edge n shows in the status register after edge n+2 and not before.
- R7: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear leaves the bit set. Status bit i corresponds to pin i.
- R8: `irq_out` is high exactly when some status bit and its mask bit are both 1.
- R9: Writes to any other byte offset change no register, and reads from any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| pin_in | input | 32 | Asynchronous pin levels, bit i is pin i |
| bus_addr | input | ADDR_W (8) | Byte offset for read and write |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that `bus_wen` and `bus_addr` are never unknown once reset is released. They also assume a write is a single-cycle pulse whose address is decoded exactly, so an unaligned offset counts as unmapped. The stimulus drives every bus signal and pin at the falling clock edge. It changes pins only between register operations and lets four clocks pass after each operation. The synchronizer pipeline is therefore settled before the next type change, clear or pin change, which lets the bench predict the status from the pin values before and after each change.

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_STAT = ADDR_W'('h0C),
  parameter logic [ADDR_W-1:0] OFS_MASK = ADDR_W'('h10),
  parameter logic [ADDR_W-1:0] OFS_TLO  = ADDR_W'('h14),
  parameter logic [ADDR_W-1:0] OFS_THI  = ADDR_W'('h18)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       pin_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  localparam int NPIN = 32;
  localparam int HALF = NPIN / 2;
  localparam logic [1:0] EV_BOTH = 2'b00;
  localparam logic [1:0] EV_RISE = 2'b01;
  localparam logic [1:0] EV_FALL = 2'b10;

  logic [NPIN-1:0] meta_q, sync_q, prev_q;
  logic [NPIN-1:0] status_q, mask_q, evt, clr;
  logic [31:0]     typ_lo_q, typ_hi_q;

  wire hit_stat = bus_wen && (bus_addr == OFS_STAT);
  wire hit_mask = bus_wen && (bus_addr == OFS_MASK);
  wire hit_tlo  = bus_wen && (bus_addr == OFS_TLO);
  wire hit_thi  = bus_wen && (bus_addr == OFS_THI);

  assign clr = hit_stat ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    localparam int SH = (HALF - 1 - (p % HALF)) * 2;
    logic [1:0] code;
    logic rise, fall;
    if (p < HALF) begin : g_lo
      assign code = typ_lo_q[SH +: 2];
    end else begin : g_hi
      assign code = typ_hi_q[SH +: 2];
    end
    assign rise = sync_q[p] & ~prev_q[p];
    assign fall = ~sync_q[p] & prev_q[p];
    assign evt[p] = (code == EV_BOTH) ? (rise | fall) :
                    (code == EV_RISE) ? rise :
                    (code == EV_FALL) ? fall :
                    ~sync_q[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      typ_lo_q <= '0;
      typ_hi_q <= '0;
    end else begin
      status_q <= (status_q & ~clr) | evt;
      if (hit_mask) mask_q   <= bus_wdata;
      if (hit_tlo)  typ_lo_q <= bus_wdata;
      if (hit_thi)  typ_hi_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_STAT: bus_rdata = status_q;
      OFS_MASK: bus_rdata = mask_q;
      OFS_TLO:  bus_rdata = typ_lo_q;
      OFS_THI:  bus_rdata = typ_hi_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_out = |(status_q & mask_q);
endmodule

// File: rtl/gpio_evt_ctrl_chk.sv
module gpio_evt_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_STAT = ADDR_W'('h0C),
  parameter logic [ADDR_W-1:0] OFS_MASK = ADDR_W'('h10),
  parameter logic [ADDR_W-1:0] OFS_TLO  = ADDR_W'('h14),
  parameter logic [ADDR_W-1:0] OFS_THI  = ADDR_W'('h18)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wen,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq_out,
  input logic [31:0]       status_q,
  input logic [31:0]       mask_q,
  input logic [31:0]       typ_lo_q,
  input logic [31:0]       typ_hi_q
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  wire [31:0] clr_v = (bus_wen && bus_addr == OFS_STAT) ? bus_wdata : 32'd0;
  wire unmapped = (bus_addr != OFS_STAT) && (bus_addr != OFS_MASK) &&
                  (bus_addr != OFS_TLO) && (bus_addr != OFS_THI);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (((($past(status_q) & ~$past(clr_v)) & ~status_q)) == 32'd0));

  assert_mask_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == OFS_MASK) |=> (mask_q == $past(bus_wdata)));

  assert_type_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == OFS_TLO) |=> (typ_lo_q == $past(bus_wdata)));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 32'd0 || status_q == 32'd0) |-> !irq_out);

  assert_ignore_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && unmapped) |=> ($stable(mask_q) && $stable(typ_lo_q) && $stable(typ_hi_q)));

  assert_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (bus_rdata == 32'd0));
endmodule

bind gpio_evt_ctrl gpio_evt_ctrl_chk #(
  .ADDR_W(ADDR_W), .OFS_STAT(OFS_STAT), .OFS_MASK(OFS_MASK),
  .OFS_TLO(OFS_TLO), .OFS_THI(OFS_THI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .status_q(status_q), .mask_q(mask_q), .typ_lo_q(typ_lo_q), .typ_hi_q(typ_hi_q)
);

// File: tb/sim_gpio_evt_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_evt_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, wen = 1'b0;
  logic [31:0] pins = '0, wdata = '0;
  logic [7:0] addr = '0;
  wire [31:0] rdata;
  wire irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] e_stat = '0, e_mask = '0, e_lo = '0, e_hi = '0;

  always #2.5 clk = ~clk;

  gpio_evt_ctrl u0 (.clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_addr(addr),
    .bus_wen(wen), .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq));

  function automatic logic [1:0] code_of(int p, logic [31:0] lo, logic [31:0] hi);
    logic [31:0] f = (p < 16) ? lo : hi;
    int sh = (15 - (p % 16)) * 2;
    return f[sh +: 2];
  endfunction

  function automatic logic [31:0] events(logic [31:0] o, logic [31:0] n,
                                         logic [31:0] lo, logic [31:0] hi);
    logic [31:0] e = '0;
    for (int p = 0; p < 32; p++)
      case (code_of(p, lo, hi))
        2'b00: e[p] = o[p] ^ n[p];
        2'b01: e[p] = ~o[p] & n[p];
        2'b10: e[p] = o[p] & ~n[p];
        default: e[p] = ~o[p] | ~n[p];
      endcase
    return e;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wen = 1'b1;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic verify_all(string tag);
    logic [31:0] d;
    rd(8'h0C, d); check({tag, " R7 status"}, d, e_stat);
    rd(8'h10, d); check("R2 mask", d, e_mask);
    rd(8'h14, d); check("R2 type lo", d, e_lo);
    rd(8'h18, d); check("R2 type hi", d, e_hi);
    check("R8 irq", {31'b0, irq}, {31'b0, |(e_stat & e_mask)});
  endtask

  task automatic do_pins(logic [31:0] v);
    @(negedge clk);
    e_stat |= events(pins, v, e_lo, e_hi);
    pins = v;
    settle();
  endtask

  task automatic do_type(logic [31:0] lo, logic [31:0] hi);
    wr(8'h14, lo); wr(8'h18, hi);
    e_lo = lo; e_hi = hi;
    e_stat |= events(pins, pins, e_lo, e_hi);
    settle();
  endtask

  task automatic do_clear(logic [31:0] w);
    wr(8'h0C, w);
    e_stat = (e_stat & ~w) | events(pins, pins, e_lo, e_hi);
    settle();
  endtask

  task automatic do_mask(logic [31:0] m);
    wr(8'h10, m); e_mask = m; settle();
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    verify_all("R1 reset");

    do_type(32'h5555_5555, 32'h5555_5555);
    @(negedge clk); pins[0] = 1'b1;
    @(negedge clk); rd(8'h0C, d); check("R6 after 1 edge", d, 32'h0);
    @(negedge clk); rd(8'h0C, d); check("R6 after 2 edges", d, 32'h0);
    @(negedge clk); rd(8'h0C, d); check("R6 after 3 edges", d, 32'h1);
    e_stat = 32'h1; settle();
    do_pins(32'h0); verify_all("R4 rising ignores fall");

    do_type(32'hAAAA_AAAA, 32'hAAAA_AAAA);
    do_pins(32'hF0F0_0000); rd(8'h0C, d); check("R4 falling ignores rise", d, 32'h1);
    do_pins(32'h0);         rd(8'h0C, d); check("R4 falling", d, 32'hF0F0_0001);

    do_type(32'h0, 32'h0); do_clear(32'hFFFF_FFFF);
    do_pins(32'h0000_00FF); rd(8'h0C, d); check("R4 both rise", d, 32'h0000_00FF);
    do_clear(32'hFFFF_FFFF);
    do_pins(32'h0);         rd(8'h0C, d); check("R4 both fall", d, 32'h0000_00FF);

    do_clear(32'hFFFF_FFFF);
    do_type(32'h8000_0000, 32'h0000_0001);
    do_pins(32'h8000_0001); rd(8'h0C, d); check("R3 field placement rise", d, 32'h8000_0000);
    do_pins(32'h0);         rd(8'h0C, d); check("R3 field placement fall", d, 32'h8000_0001);

    do_clear(32'hFFFF_FFFF);
    do_type(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(8'h0C, d); check("R5 low level", d, 32'hFFFF_FFFF);
    do_pins(32'h0000_FFFF); rd(8'h0C, d); check("R7 sticky", d, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, d); check("R7 event wins over clear", d, 32'hFFFF_0000);
    e_stat = 32'hFFFF_0000; settle();
    rd(8'h0C, d); check("R5 resets while low", d, 32'hFFFF_0000);
    do_clear(32'h0); rd(8'h0C, d); check("R7 write zero", d, 32'hFFFF_0000);

    do_mask(32'h0000_0001); check("R8 irq off", {31'b0, irq}, 32'h0);
    do_mask(32'h0001_0000); check("R8 irq on", {31'b0, irq}, 32'h1);

    foreach (d[i]) if (i < 5) begin
      logic [7:0] a = (i == 0) ? 8'h00 : (i == 1) ? 8'h04 : (i == 2) ? 8'h08 :
                      (i == 3) ? 8'h1C : 8'h0D;
      wr(a, $urandom); settle();
      rd(a, d); check("R9 unmapped read", d, 32'h0);
      verify_all("R9 unmapped write");
    end

    for (int it = 0; it < 400; it++) begin
      case ($urandom_range(0, 4))
        0, 1: do_pins(pins ^ ($urandom & $urandom));
        2: do_type($urandom, $urandom);
        3: do_clear($urandom);
        default: do_mask($urandom);
      endcase
      verify_all("R4 R5 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule